// File: doc/BRIEF.md
# Coprocessor Host Register Bank

This block is the register file that a host processor uses to control and inspect a small interrupt-driven coprocessor. The host reaches it over a 16-bit bus with two byte-lane enables. Every bus access captures its word offset in a register, and the read data is selected from that captured offset. The read value therefore appears one cycle after the access and stays there until the next access.

Several registers use a mask-and-value write. The upper byte of the written word tells the block which bits of the lower byte may change, so these registers only change on a full-word write. Other registers take plain byte-lane writes. The vector base register is locked while the engine is enabled. Eight interrupt flag words hold one bit per channel. The channel-request and clear inputs set and clear these bits, and the host can only read them. A word-wide write port from the coprocessor side updates the program counter and the general registers. When both sides write the same register in one cycle, the coprocessor-side write wins.

Top module: `cpr_regbank`

## Requirements
- R1: After reset, all registers read 0x0000 except two. The vector base (offset 3) reads 0xFE00, and flag word 0 (offset 16) reads 0x0001. The engine-enable output is 0.
- R2: The control register is at offset 0 and reads its value bits in [2:0]: enable in bit 0, freeze in bit 1, fake-activity in bit 2. On a full-word write, value bit i takes wdata[i] only if mask bit wdata[8+i] is 1, and keeps its old value otherwise. The engine-enable output follows bit 0.
- R3: A write to the control register (offset 0), trigger register (offset 4) or semaphore register (offset 5) that enables only one byte lane changes no bit. This holds even when the data is 0xFFFF.
- R4: The trigger (offset 4) and semaphore (offset 5) registers are 8 bits wide. On a full-word write, bit i takes wdata[i] only if wdata[8+i] is 1. Writing 0xFFFF reads back 0x00FF, and writing 0xFF00 then reads back 0x0000.
- R5: In the vector base register (offset 3), bit 0 always reads 0. Each enabled byte lane updates only its own byte: be[0] selects bits 7:0 and be[1] selects bits 15:8.
- R6: While control bit 0 (enable) is 1, host writes to the vector base register are ignored.
- R7: The condition code register (offset 6) holds 4 bits. A low-lane write of 0xFF reads back 0x000F. The channel ID register (offset 1) holds 7 bits and is written from the low lane.
- R8: The stack pointer (offset 2), the program counter (offset 8) and R1 to R7 (offsets 9 to 15) take independent byte-lane writes. A full-word write replaces both bytes.
- R9: Flag word k is at offset 16+k and holds channels 16k to 16k+15, with channel c at bit c mod 16. A one-cycle pulse on chan_req[c] sets flag c, and a pulse on flag_clr[c] clears it. If both arrive in the same cycle, the set wins. Host writes to the flag words have no effect.
- R10: bus_rdata shows the register at the offset captured by the most recent access, and holds it while bus_req is low. Offset 7 and offsets 24 to 31 read 0x0000, and writes to them change nothing.
- R11: cp_we writes cp_wdata as a full word into the program counter (cp_sel 0) or Rn (cp_sel n). In the same cycle it overrides any host write to that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Host access strobe; captures the offset |
| bus_wr | input | 1 | Access is a write |
| bus_addr | input | 5 | Word offset |
| bus_be | input | 2 | Byte-lane enables, bit 0 for the low byte |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Read data for the captured offset |
| cp_we | input | 1 | Coprocessor-side register write |
| cp_sel | input | 3 | 0 selects the program counter, n selects Rn |
| cp_wdata | input | 16 | Coprocessor-side write data |
| chan_req | input | NUM_CH | Per-channel flag set pulses |
| flag_clr | input | NUM_CH | Per-channel flag clear pulses |
| eng_en | output | 1 | Engine enable (control bit 0) |

## Verification
The hardest cases to reach are the collisions. One is a host write and a coprocessor write landing on the same general register in the same cycle. Another is a set and a clear landing on the same flag bit in the same cycle. A third is a vector base write arriving while the engine is enabled. Directed sequences set up each of these on purpose: they line up the side inputs with a bus access at the same falling edge, or enable the engine through a masked control write just before writing the vector base. A long phase of random accesses then mixes these inputs with random lane enables, random offsets and random coprocessor writes. Throughout, a behavioural model checks every cycle.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
    localparam int ADDR_W    = 5;
    localparam int CTL_BITS  = 3;
    localparam int SEM_BITS  = 8;
    localparam int CCR_BITS  = 4;
    localparam int CHID_BITS = 7;
    localparam int GPR_N     = 8;
    localparam int GPR_IW    = $clog2(GPR_N);

    localparam logic [ADDR_W-1:0] OFF_CTL  = 5'd0;
    localparam logic [ADDR_W-1:0] OFF_CHID = 5'd1;
    localparam logic [ADDR_W-1:0] OFF_ISP  = 5'd2;
    localparam logic [ADDR_W-1:0] OFF_VBR  = 5'd3;
    localparam logic [ADDR_W-1:0] OFF_SWT  = 5'd4;
    localparam logic [ADDR_W-1:0] OFF_SEM  = 5'd5;
    localparam logic [ADDR_W-1:0] OFF_CCR  = 5'd6;
    localparam logic [1:0]        GRP_GPR  = 2'b01;
    localparam logic [1:0]        GRP_FLAG = 2'b10;
    localparam logic [15:0]       VBR_RST  = 16'hFE00;

    typedef struct packed {
        logic [CHID_BITS-1:0] chid;
        logic [15:0]          isp;
        logic [15:0]          vbr;
        logic [CCR_BITS-1:0]  ccr;
        logic [ADDR_W-1:0]    addr;
    } bank_state_t;
endpackage

// File: rtl/cpr_mask_reg.sv
module cpr_mask_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] val,
    output logic [W-1:0] q
);
    logic [W-1:0] q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (wr_en) q_d = (q_q & ~mask) | (val & mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q = q_q;

    AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (((q_q ^ $past(q_q)) & ~$past(mask)) == '0)); // R2
    AST_MASKED_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (((q_q ^ $past(val)) & $past(mask)) == '0)); // R4
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q_q)); // R3
endmodule

// File: rtl/cpr_gpr_file.sv
module cpr_gpr_file
    import cpr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      h_we,
    input  logic [GPR_IW-1:0]         h_idx,
    input  logic [1:0]                h_be,
    input  logic [W-1:0]              h_wdata,
    input  logic                      cp_we,
    input  logic [GPR_IW-1:0]         cp_idx,
    input  logic [W-1:0]              cp_wdata,
    output logic [GPR_N-1:0][W-1:0]   regs
);
    localparam int HB = W / 2;

    logic [GPR_N-1:0][W-1:0] r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (h_we) begin
            if (h_be[0]) r_d[h_idx][HB-1:0] = h_wdata[HB-1:0];
            if (h_be[1]) r_d[h_idx][W-1:HB] = h_wdata[W-1:HB];
        end
        if (cp_we) r_d[cp_idx] = cp_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign regs = r_q;

    AST_CP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        cp_we |=> (r_q[$past(cp_idx)] == $past(cp_wdata))); // R11
    AST_HI_LANE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && !h_be[1] && !(cp_we && cp_idx == h_idx))
        |=> (r_q[$past(h_idx)][W-1:HB] == $past(r_q[h_idx][W-1:HB]))); // R8
endmodule

// File: rtl/cpr_flag_bank.sv
module cpr_flag_bank #(
    parameter int N = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    localparam logic [N-1:0] RST_VAL = {{(N-1){1'b0}}, 1'b1};

    logic [N-1:0] f_d, f_q;

    always_comb begin
        f_d = (f_q & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= RST_VAL;
        else        f_q <= f_d;
    end

    assign flags = f_q;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((f_q & $past(set)) == $past(set))); // R9
    AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr) |=> ((f_q & $past(clr) & ~$past(set)) == '0)); // R9
endmodule

// File: rtl/cpr_regbank.sv
module cpr_regbank
    import cpr_pkg::*;
#(
    parameter int NUM_CH = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_wr,
    input  logic [4:0]           bus_addr,
    input  logic [1:0]           bus_be,
    input  logic [15:0]          bus_wdata,
    output logic [15:0]          bus_rdata,
    input  logic                 cp_we,
    input  logic [2:0]           cp_sel,
    input  logic [15:0]          cp_wdata,
    input  logic [NUM_CH-1:0]    chan_req,
    input  logic [NUM_CH-1:0]    flag_clr,
    output logic                 eng_en
);
    localparam int FLAG_WORDS = NUM_CH / 16;

    bank_state_t st_d, st_q;
    logic [CTL_BITS-1:0]     ctl_q;
    logic [SEM_BITS-1:0]     swt_q, sem_q;
    logic [GPR_N-1:0][15:0]  gpr_q;
    logic [NUM_CH-1:0]       flags_q;

    logic host_wr, full_word, ctl_wr, swt_wr, sem_wr, gpr_wr, host_miss;

    assign host_wr   = bus_req && bus_wr;
    assign full_word = &bus_be;
    assign ctl_wr    = host_wr && full_word && (bus_addr == OFF_CTL);
    assign swt_wr    = host_wr && full_word && (bus_addr == OFF_SWT);
    assign sem_wr    = host_wr && full_word && (bus_addr == OFF_SEM);
    assign gpr_wr    = host_wr && (bus_addr[4:3] == GRP_GPR);
    assign host_miss = host_wr && (bus_addr > OFF_CCR) && (bus_addr[4:3] != GRP_GPR);

    cpr_mask_reg #(.W(CTL_BITS)) u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr),
        .mask(bus_wdata[8 +: CTL_BITS]), .val(bus_wdata[CTL_BITS-1:0]), .q(ctl_q)
    );
    cpr_mask_reg #(.W(SEM_BITS)) u_swt (
        .clk(clk), .rst_n(rst_n), .wr_en(swt_wr),
        .mask(bus_wdata[15:8]), .val(bus_wdata[7:0]), .q(swt_q)
    );
    cpr_mask_reg #(.W(SEM_BITS)) u_sem (
        .clk(clk), .rst_n(rst_n), .wr_en(sem_wr),
        .mask(bus_wdata[15:8]), .val(bus_wdata[7:0]), .q(sem_q)
    );
    cpr_gpr_file #(.W(16)) u_gpr (
        .clk(clk), .rst_n(rst_n),
        .h_we(gpr_wr), .h_idx(bus_addr[2:0]), .h_be(bus_be), .h_wdata(bus_wdata),
        .cp_we(cp_we), .cp_idx(cp_sel), .cp_wdata(cp_wdata), .regs(gpr_q)
    );
    cpr_flag_bank #(.N(NUM_CH)) u_flags (
        .clk(clk), .rst_n(rst_n), .set(chan_req), .clr(flag_clr), .flags(flags_q)
    );

    always_comb begin
        st_d = st_q;
        if (bus_req) st_d.addr = bus_addr;
        if (host_wr) begin
            case (bus_addr)
                OFF_CHID: if (bus_be[0]) st_d.chid = bus_wdata[CHID_BITS-1:0];
                OFF_ISP: begin
                    if (bus_be[0]) st_d.isp[7:0]  = bus_wdata[7:0];
                    if (bus_be[1]) st_d.isp[15:8] = bus_wdata[15:8];
                end
                OFF_VBR: if (!ctl_q[0]) begin
                    if (bus_be[0]) st_d.vbr[7:0]  = bus_wdata[7:0];
                    if (bus_be[1]) st_d.vbr[15:8] = bus_wdata[15:8];
                    st_d.vbr[0] = 1'b0;
                end
                OFF_CCR: if (bus_be[0]) st_d.ccr = bus_wdata[CCR_BITS-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.vbr  <= VBR_RST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (st_q.addr)
            OFF_CTL:  bus_rdata = {{(16-CTL_BITS){1'b0}}, ctl_q};
            OFF_CHID: bus_rdata = {{(16-CHID_BITS){1'b0}}, st_q.chid};
            OFF_ISP:  bus_rdata = st_q.isp;
            OFF_VBR:  bus_rdata = st_q.vbr;
            OFF_SWT:  bus_rdata = {8'h00, swt_q};
            OFF_SEM:  bus_rdata = {8'h00, sem_q};
            OFF_CCR:  bus_rdata = {{(16-CCR_BITS){1'b0}}, st_q.ccr};
            default: begin
                if (st_q.addr[4:3] == GRP_GPR)
                    bus_rdata = gpr_q[st_q.addr[2:0]];
                else if (st_q.addr[4:3] == GRP_FLAG && int'(st_q.addr[2:0]) < FLAG_WORDS)
                    bus_rdata = flags_q[{st_q.addr[2:0], 4'b0000} +: 16];
            end
        endcase
    end

    assign eng_en = ctl_q[0];

    AST_VBR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && bus_addr == OFF_VBR && eng_en) |=> $stable(st_q.vbr)); // R6
    AST_MISS_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        host_miss |=> ($stable({st_q.chid, st_q.isp, st_q.vbr, st_q.ccr})
                       && $stable(ctl_q) && $stable(swt_q) && $stable(sem_q))); // R10
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> $stable(st_q.addr)); // R10
endmodule

// File: tb/sim_cpr_regbank.sv
module sim_cpr_regbank;
    localparam int NCH = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_req = 0, bus_wr = 0;
    logic [4:0] bus_addr = 0;
    logic [1:0] bus_be = 0;
    logic [15:0] bus_wdata = 0, bus_rdata;
    logic cp_we = 0;
    logic [2:0] cp_sel = 0;
    logic [15:0] cp_wdata = 0;
    logic [NCH-1:0] chan_req = '0, flag_clr = '0;
    logic eng_en;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cpr_regbank #(.NUM_CH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cp_we(cp_we), .cp_sel(cp_sel), .cp_wdata(cp_wdata),
        .chan_req(chan_req), .flag_clr(flag_clr), .eng_en(eng_en)
    );

    // behavioural reference model
    logic [15:0] m_ctl, m_chid, m_isp, m_vbr, m_swt, m_sem, m_ccr;
    logic [15:0] m_gpr [8];
    logic [NCH-1:0] m_flag;
    logic [4:0] m_addr;

    function automatic logic [15:0] lanes(logic [15:0] old, logic [1:0] be, logic [15:0] d);
        logic [15:0] r = old;
        if (be[0]) r[7:0] = d[7:0];
        if (be[1]) r[15:8] = d[15:8];
        return r;
    endfunction

    function automatic logic [15:0] masked(logic [15:0] old, logic [15:0] d, logic [15:0] keep);
        logic [15:0] m = {8'h00, d[15:8]} & keep;
        return (old & ~m) | (d & m);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctl = 0; m_chid = 0; m_isp = 0; m_vbr = 16'hFE00; m_swt = 0; m_sem = 0; m_ccr = 0;
            foreach (m_gpr[i]) m_gpr[i] = 0;
            m_flag = '0; m_flag[0] = 1'b1; m_addr = 0;
        end else begin
            if (bus_req) begin
                if (bus_wr) begin
                    if (bus_addr == 0 && bus_be == 2'b11) m_ctl = masked(m_ctl, bus_wdata, 16'h0007);
                    else if (bus_addr == 1 && bus_be[0]) m_chid = {9'b0, bus_wdata[6:0]};
                    else if (bus_addr == 2) m_isp = lanes(m_isp, bus_be, bus_wdata);
                    else if (bus_addr == 3 && !m_ctl[0]) m_vbr = lanes(m_vbr, bus_be, bus_wdata) & 16'hFFFE;
                    else if (bus_addr == 4 && bus_be == 2'b11) m_swt = masked(m_swt, bus_wdata, 16'h00FF);
                    else if (bus_addr == 5 && bus_be == 2'b11) m_sem = masked(m_sem, bus_wdata, 16'h00FF);
                    else if (bus_addr == 6 && bus_be[0]) m_ccr = {12'b0, bus_wdata[3:0]};
                    else if (bus_addr >= 8 && bus_addr <= 15)
                        m_gpr[bus_addr - 8] = lanes(m_gpr[bus_addr - 8], bus_be, bus_wdata);
                end
                m_addr = bus_addr;
            end
            if (cp_we) m_gpr[cp_sel] = cp_wdata;
            m_flag = (m_flag & ~flag_clr) | chan_req;
        end
    end

    function automatic logic [15:0] model_rd(logic [4:0] a);
        case (a)
            0: return m_ctl;  1: return m_chid; 2: return m_isp; 3: return m_vbr;
            4: return m_swt;  5: return m_sem;  6: return m_ccr;
            default: begin
                if (a >= 8 && a <= 15) return m_gpr[a - 8];
                if (a >= 16 && a <= 23) return m_flag[(a - 16) * 16 +: 16];
                return 16'h0000;
            end
        endcase
    endfunction

    function automatic string tag_of(logic [4:0] a);
        case (a)
            0: return "R2"; 1: return "R7"; 2: return "R8"; 3: return "R5";
            4, 5: return "R4"; 6: return "R7";
            default: return (a >= 8 && a <= 15) ? "R8" : (a >= 16 && a <= 23) ? "R9" : "R10";
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_chk++;
            if (bus_rdata !== model_rd(m_addr) || eng_en !== m_ctl[0]) begin
                n_fail++;
                $display("FAIL %s model compare offset %0d: got %h/%b expected %h/%b",
                         tag_of(m_addr), m_addr, bus_rdata, eng_en, model_rd(m_addr), m_ctl[0]);
            end
        end
    end

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic [4:0] a, input logic [1:0] be, input logic [15:0] d);
        bus_req = 1; bus_wr = wr; bus_addr = a; bus_be = be; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_req = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [4:0] a);
        acc(1'b0, a, 2'b11, 16'h0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung expected completion");
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset values
        rd(0);  chk(bus_rdata, 16'h0000, "R1");
        chk({15'b0, eng_en}, 16'h0000, "R1");
        rd(3);  chk(bus_rdata, 16'hFE00, "R1");
        rd(16); chk(bus_rdata, 16'h0001, "R1");
        rd(17); chk(bus_rdata, 16'h0000, "R1");
        rd(15); chk(bus_rdata, 16'h0000, "R1");
        // R2 masked control
        acc(1, 0, 2'b11, 16'h0707); chk(bus_rdata, 16'h0007, "R2");
        chk({15'b0, eng_en}, 16'h0001, "R2");
        acc(1, 0, 2'b11, 16'h0100); chk(bus_rdata, 16'h0006, "R2");
        acc(1, 0, 2'b11, 16'h0600); chk(bus_rdata, 16'h0000, "R2");
        // R3 single-lane writes ignored
        acc(1, 0, 2'b10, 16'hFFFF); chk(bus_rdata, 16'h0000, "R3");
        acc(1, 0, 2'b01, 16'hFFFF); chk(bus_rdata, 16'h0000, "R3");
        acc(1, 4, 2'b01, 16'hFF55); chk(bus_rdata, 16'h0000, "R3");
        acc(1, 5, 2'b10, 16'hFFFF); chk(bus_rdata, 16'h0000, "R3");
        // R4 trigger / semaphore
        acc(1, 4, 2'b11, 16'hFFFF); chk(bus_rdata, 16'h00FF, "R4");
        acc(1, 4, 2'b11, 16'hFF00); chk(bus_rdata, 16'h0000, "R4");
        acc(1, 5, 2'b11, 16'hFFFF); chk(bus_rdata, 16'h00FF, "R4");
        acc(1, 5, 2'b11, 16'h0F00); chk(bus_rdata, 16'h00F0, "R4");
        // R5 vector base
        acc(1, 3, 2'b11, 16'h5555); chk(bus_rdata, 16'h5554, "R5");
        acc(1, 3, 2'b11, 16'hAAAA); chk(bus_rdata, 16'hAAAA, "R5");
        acc(1, 3, 2'b01, 16'hFF55); chk(bus_rdata, 16'hAA54, "R5");
        acc(1, 3, 2'b10, 16'h55AA); chk(bus_rdata, 16'h5554, "R5");
        // R6 lock while enabled
        acc(1, 0, 2'b11, 16'h0101); chk({15'b0, eng_en}, 16'h0001, "R6");
        acc(1, 3, 2'b11, 16'hFFFF); chk(bus_rdata, 16'h5554, "R6");
        acc(1, 0, 2'b11, 16'h0100); chk({15'b0, eng_en}, 16'h0000, "R6");
        acc(1, 3, 2'b11, 16'h1234); chk(bus_rdata, 16'h1234, "R6");
        // R7 narrow registers
        acc(1, 6, 2'b01, 16'hFFFF); chk(bus_rdata, 16'h000F, "R7");
        acc(1, 6, 2'b11, 16'hFFF0); chk(bus_rdata, 16'h0000, "R7");
        acc(1, 1, 2'b01, 16'hFFFF); chk(bus_rdata, 16'h007F, "R7");
        // R8 byte lanes
        acc(1, 8, 2'b01, 16'hFF55); chk(bus_rdata, 16'h0055, "R8");
        acc(1, 8, 2'b10, 16'hAAFF); chk(bus_rdata, 16'hAA55, "R8");
        acc(1, 8, 2'b11, 16'h9966); chk(bus_rdata, 16'h9966, "R8");
        acc(1, 11, 2'b10, 16'h54FF); chk(bus_rdata, 16'h5400, "R8");
        acc(1, 2, 2'b11, 16'hBEEF); chk(bus_rdata, 16'hBEEF, "R8");
        // R9 flags
        chan_req[37] = 1; @(posedge clk); @(negedge clk); chan_req = '0;
        rd(18); chk(bus_rdata, 16'h0020, "R9");
        acc(1, 18, 2'b11, 16'hFFFF); chk(bus_rdata, 16'h0020, "R9");
        flag_clr[37] = 1; chan_req[40] = 1; flag_clr[40] = 1;
        @(posedge clk); @(negedge clk); chan_req = '0; flag_clr = '0;
        rd(18); chk(bus_rdata, 16'h0100, "R9");
        chan_req[127] = 1; flag_clr[0] = 1; @(posedge clk); @(negedge clk);
        chan_req = '0; flag_clr = '0;
        rd(23); chk(bus_rdata, 16'h8000, "R9");
        rd(16); chk(bus_rdata, 16'h0000, "R9");
        // R10 unmapped and held read
        acc(1, 7, 2'b11, 16'hFFFF); chk(bus_rdata, 16'h0000, "R10");
        acc(1, 24, 2'b11, 16'hFFFF); chk(bus_rdata, 16'h0000, "R10");
        rd(3); repeat (2) @(negedge clk); chk(bus_rdata, 16'h1234, "R10");
        // R11 coprocessor wins
        cp_we = 1; cp_sel = 2; cp_wdata = 16'h2222;
        acc(1, 10, 2'b11, 16'h1111); cp_we = 0;
        chk(bus_rdata, 16'h2222, "R11");
        cp_we = 1; cp_sel = 5; cp_wdata = 16'hC0DE;
        acc(1, 13, 2'b01, 16'h00AA); cp_we = 0;
        chk(bus_rdata, 16'hC0DE, "R11");
        cp_we = 1; cp_sel = 0; cp_wdata = 16'h2094; @(posedge clk); @(negedge clk); cp_we = 0;
        rd(8); chk(bus_rdata, 16'h2094, "R11");
        // random mix, checked against the model every cycle
        for (int i = 0; i < 1500; i++) begin
            bus_req = ($urandom % 4) != 0;
            bus_wr = $urandom % 2;
            bus_addr = $urandom % 32;
            bus_be = $urandom % 4;
            bus_wdata = $urandom;
            cp_we = ($urandom % 4) == 0;
            cp_sel = $urandom % 8;
            cp_wdata = $urandom;
            chan_req = '0; flag_clr = '0;
            if ($urandom % 3 == 0) chan_req[$urandom % NCH] = 1'b1;
            if ($urandom % 3 == 0) flag_clr[$urandom % NCH] = 1'b1;
            @(posedge clk); @(negedge clk);
        end
        bus_req = 0; cp_we = 0; chan_req = '0; flag_clr = '0;
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule